// File: doc/BRIEF.md
# Vector Scaled Address Generator

This block decodes a 32-bit vector address-compute instruction word and produces one address per lane. Each address is the sum of a base lane and a scaled offset lane. The base comes from the first vector operand and the offset from the second. The offset can take one of three forms: the whole lane as an unsigned value (32-bit or 64-bit lanes), or the low 32 bits of a 64-bit lane extended with sign or with zeros. A 2-bit shift field scales the offset by 1, 2, 4 or 8 before a modular add.

The result is registered. It appears one clock after the input strobe, together with the destination register index taken from the word. No predicate applies, so every lane is computed. The block raises a one-cycle illegal flag in two cases:

- the word is not one of the three recognised forms;
- streaming mode is active while the full-ISA-in-streaming capability is not both present and enabled.

When the flag is raised, the result register and the destination index are left unchanged.

Top module: `vec_addr_gen`

## Requirements
- R1: A word is recognised only when bits 31:24 equal 8'b00000100, bit 21 is 1 and bits 15:12 equal 4'b1010. Any other word raises illegal_o and does not raise res_valid_o.
- R2: With bit 23 = 1 the lanes are packed. Bit 22 = 0 selects 32-bit lanes and bit 22 = 1 selects 64-bit lanes. The whole offset lane is used as an unsigned value.
- R3: With bits 23:22 = 2'b00 the lanes are 64 bits wide. The low 32 bits of each offset lane are sign-extended, and offset bits 63:32 have no effect.
- R4: With bits 23:22 = 2'b01 the lanes are 64 bits wide. The low 32 bits of each offset lane are zero-extended, and offset bits 63:32 have no effect.
- R5: Bits 11:10 give a left shift of 0 to 3 that is applied to the extended offset before the add.
- R6: Each result lane is (base + scaled offset) modulo 2^lane width. Overflow wraps with no other effect.
- R7: All VLEN/lane-width lanes are computed on every accepted word. Lane k occupies bits k*width and up.
- R8: When streaming_i is 1 and full_isa_i is 0, the word is illegal. When streaming_i is 1 and full_isa_i is 1, or when streaming_i is 0, a recognised word is legal.
- R9: On an illegal word, illegal_o is high for exactly the cycle in which res_valid_o would have been high. res_valid_o stays low, and result_o and dst_o keep their previous values.
- R10: result_o, dst_o (the word's bits 4:0) and res_valid_o update on the first clock edge after valid_i is sampled high. Both strobes are low in the cycle after valid_i is sampled low.
- R11: After reset, result_o, dst_o, res_valid_o and illegal_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and operands are present |
| insn_i | input | 32 | Instruction word |
| base_i | input | VLEN | Base address vector |
| offs_i | input | VLEN | Offset or index vector |
| streaming_i | input | 1 | Streaming mode is active |
| full_isa_i | input | 1 | Full ISA in streaming mode is present and enabled |
| result_o | output | VLEN | Address vector |
| dst_o | output | 5 | Destination register index |
| res_valid_o | output | 1 | result_o and dst_o were written this cycle |
| illegal_o | output | 1 | The last accepted word was illegal |

## Verification
Each lane of the operand vectors gets its own value, so a lane mix-up or a wrong lane width shows up as a mismatch against a behavioural model. The three forms are tried with all four shift amounts:

- Packed 32-bit and packed 64-bit runs separate lane width from offset width.
- Unpacked runs use offsets that are negative in their low 32 bits, which separates sign extension from zero extension.
- The same unpacked runs are repeated with garbage in offset bits 63:32, which shows that those bits are ignored.

Bases near all-ones expose any carry out of a lane. Words with a single wrong fixed bit, and the streaming/full-ISA combinations, show that illegal words leave the result and the destination index unchanged.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    OFS_FULL = 2'd0,
    OFS_SEXT = 2'd1,
    OFS_ZEXT = 2'd2
  } ofs_mode_e;

  typedef struct packed {
    logic      match;
    logic      wide;
    ofs_mode_e mode;
    logic [1:0] shift;
    logic [4:0] dst;
  } dec_t;

  localparam logic [7:0] OPC_HI  = 8'b0000_0100;
  localparam logic [3:0] OPC_MID = 4'b1010;
endpackage

// File: rtl/vag_decode.sv
module vag_decode
  import vag_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.match = (insn_i[31:24] == OPC_HI) && insn_i[21] && (insn_i[15:12] == OPC_MID);
    dec_o.shift = insn_i[11:10];
    dec_o.dst   = insn_i[4:0];
    if (insn_i[23]) begin
      dec_o.wide = insn_i[22];
      dec_o.mode = OFS_FULL;
    end else begin
      dec_o.wide = 1'b1;
      dec_o.mode = insn_i[22] ? OFS_ZEXT : OFS_SEXT;
    end
  end
endmodule

// File: rtl/vag_lane.sv
module vag_lane
  import vag_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] offs_i,
  input  ofs_mode_e    mode_i,
  input  logic [1:0]   shift_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] ext;

  always_comb begin
    unique case (mode_i)
      OFS_SEXT: ext = W'($signed(offs_i[31:0]));
      OFS_ZEXT: ext = W'(offs_i[31:0]);
      default:  ext = offs_i;
    endcase
    sum_o = base_i + (ext << shift_i);
  end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [VLEN-1:0] base_i,
  input  logic [VLEN-1:0] offs_i,
  input  logic            streaming_i,
  input  logic            full_isa_i,
  output logic [VLEN-1:0] result_o,
  output logic [4:0]      dst_o,
  output logic            res_valid_o,
  output logic            illegal_o
);
  localparam int unsigned N32 = VLEN / 32;
  localparam int unsigned N64 = VLEN / 64;

  dec_t            dec;
  logic [VLEN-1:0] res32, res64, res_nxt;
  logic            bad;

  vag_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  for (genvar k = 0; k < N32; k++) begin : g_l32
    vag_lane #(.W(32)) u_lane (
      .base_i (base_i[k*32 +: 32]),
      .offs_i (offs_i[k*32 +: 32]),
      .mode_i (OFS_FULL),
      .shift_i(dec.shift),
      .sum_o  (res32[k*32 +: 32])
    );
  end

  for (genvar k = 0; k < N64; k++) begin : g_l64
    vag_lane #(.W(64)) u_lane (
      .base_i (base_i[k*64 +: 64]),
      .offs_i (offs_i[k*64 +: 64]),
      .mode_i (dec.mode),
      .shift_i(dec.shift),
      .sum_o  (res64[k*64 +: 64])
    );
  end

  assign res_nxt = dec.wide ? res64 : res32;
  assign bad     = !dec.match || (streaming_i && !full_isa_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      dst_o       <= '0;
      res_valid_o <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      res_valid_o <= valid_i && !bad;
      illegal_o   <= valid_i && bad;
      if (valid_i && !bad) begin
        result_o <= res_nxt;
        dst_o    <= dec.dst;
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && illegal_o)); // R9
  AST_ILLEGAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(result_o) && $stable(dst_o))); // R9
  AST_STREAM_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && streaming_i && !full_isa_i) |=> (illegal_o && !res_valid_o)); // R8
  AST_BAD_OPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[31:24] != OPC_HI) |=> illegal_o); // R1
  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!res_valid_o && !illegal_o)); // R10
  AST_DST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (dst_o == $past(insn_i[4:0]))); // R10
endmodule

// File: tb/vec_addr_gen_tb.sv
module vec_addr_gen_tb_top;
  localparam int unsigned VLEN = 256;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [VLEN-1:0] base_i = '0;
  logic [VLEN-1:0] offs_i = '0;
  logic            streaming_i = 1'b0;
  logic            full_isa_i = 1'b0;
  logic [VLEN-1:0] result_o;
  logic [4:0]      dst_o;
  logic            res_valid_o;
  logic            illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vec_addr_gen #(.VLEN(VLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .insn_i(insn_i),
    .base_i(base_i), .offs_i(offs_i), .streaming_i(streaming_i),
    .full_isa_i(full_isa_i), .result_o(result_o), .dst_o(dst_o),
    .res_valid_o(res_valid_o), .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cls: 0 packed, 1 unpacked signed, 2 unpacked unsigned
  function automatic logic [31:0] enc(input int cls, input bit sz, input logic [1:0] msz,
                                      input logic [4:0] zd);
    logic b23, b22;
    b23 = (cls == 0);
    b22 = (cls == 0) ? sz : (cls == 2);
    return {8'b0000_0100, b23, b22, 1'b1, 5'd7, 4'b1010, msz, 5'd3, zd};
  endfunction

  function automatic logic [VLEN-1:0] pat(input logic [31:0] seed);
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++)
      v[k*32 +: 32] = (seed * (k + 1)) ^ (32'h9E37_79B9 * k) ^ {k[7:0], 24'h0};
    return v;
  endfunction

  function automatic logic [VLEN-1:0] model(input logic [31:0] w, input logic [VLEN-1:0] b,
                                            input logic [VLEN-1:0] o);
    logic [VLEN-1:0] r;
    logic [63:0] x;
    int sh;
    sh = int'(w[11:10]);
    if (w[23] && !w[22]) begin
      for (int k = 0; k < VLEN / 32; k++)
        r[k*32 +: 32] = b[k*32 +: 32] + (o[k*32 +: 32] << sh);
    end else begin
      for (int k = 0; k < VLEN / 64; k++) begin
        x = o[k*64 +: 64];
        if (!w[23]) x = w[22] ? {32'h0, x[31:0]} : {{32{x[31]}}, x[31:0]};
        r[k*64 +: 64] = b[k*64 +: 64] + (x << sh);
      end
    end
    return r;
  endfunction

  task automatic issue(input logic [31:0] w, input logic [VLEN-1:0] b,
                       input logic [VLEN-1:0] o, input bit st, input bit fa);
    @(negedge clk);
    insn_i = w; base_i = b; offs_i = o; streaming_i = st; full_isa_i = fa; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic expect_ok(input logic [31:0] w, input logic [VLEN-1:0] b,
                           input logic [VLEN-1:0] o, input string req);
    logic [VLEN-1:0] e;
    e = model(w, b, o);
    issue(w, b, o, 1'b0, 1'b0);
    chk(result_o == e, req, result_o, e);
    chk(res_valid_o && !illegal_o && dst_o == w[4:0], {req, " R10 strobe/dst"},
        VLEN'({res_valid_o, illegal_o, dst_o}), VLEN'({2'b10, w[4:0]}));
  endtask

  task automatic expect_bad(input logic [31:0] w, input bit st, input bit fa, input string req);
    logic [VLEN-1:0] pr;
    logic [4:0] pd;
    pr = result_o; pd = dst_o;
    issue(w, pat(32'h5555_1234), pat(32'h0F0F_7777), st, fa);
    chk(illegal_o && !res_valid_o, {req, " R9 strobes"}, VLEN'({res_valid_o, illegal_o}), VLEN'(2'b01));
    chk(result_o == pr && dst_o == pd, {req, " R9 hold"}, result_o, pr);
    @(negedge clk);
    chk(!illegal_o && !res_valid_o, {req, " R9 one cycle"}, VLEN'({res_valid_o, illegal_o}), '0);
  endtask

  task automatic t_reset();
    chk(result_o == '0 && dst_o == '0 && !res_valid_o && !illegal_o, "R11 reset",
        result_o, '0);
  endtask

  task automatic t_packed();
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        expect_ok(enc(0, s[0], m[1:0], 5'(m + 4 * s + 1)), pat(32'h1357_9BDF + m),
                  pat(32'hCAFE_0011 * (s + 1)), "R2 R5 R7 packed");
  endtask

  task automatic t_unpacked();
    logic [VLEN-1:0] o, o2;
    o = pat(32'h8123_4567);
    for (int k = 0; k < VLEN / 64; k++) o[k*64 +: 32] = 32'h8000_0000 | 32'(k * 3); // negative low halves
    o2 = o;
    for (int k = 0; k < VLEN / 64; k++) o2[k*64 + 32 +: 32] = 32'hDEAD_BEEF ^ 32'(k);
    for (int m = 0; m < 4; m++) begin
      expect_ok(enc(1, 1'b0, m[1:0], 5'd10), pat(32'h7000_0001), o, "R3 R5 signed");
      expect_ok(enc(1, 1'b0, m[1:0], 5'd11), pat(32'h7000_0001), o2, "R3 upper ignored");
      expect_ok(enc(2, 1'b0, m[1:0], 5'd12), pat(32'h7000_0001), o, "R4 R5 unsigned");
      expect_ok(enc(2, 1'b0, m[1:0], 5'd13), pat(32'h7000_0001), o2, "R4 upper ignored");
    end
  endtask

  task automatic t_wrap();
    logic [VLEN-1:0] b;
    b = '1;
    expect_ok(enc(0, 1'b0, 2'd3, 5'd20), b, pat(32'h0000_0101), "R6 wrap 32");
    expect_ok(enc(0, 1'b1, 2'd2, 5'd21), b, pat(32'h0000_0101), "R6 wrap 64");
    expect_ok(enc(2, 1'b0, 2'd1, 5'd22), b, pat(32'hFFFF_0001), "R6 wrap unsigned");
  endtask

  task automatic t_bad_words();
    logic [31:0] g;
    g = enc(0, 1'b1, 2'd1, 5'd30);
    expect_bad(g ^ 32'h0100_0000, 1'b0, 1'b0, "R1 bit24");
    expect_bad(g ^ 32'h0020_0000, 1'b0, 1'b0, "R1 bit21");
    expect_bad(g ^ 32'h0000_4000, 1'b0, 1'b0, "R1 bit14");
    expect_bad(32'h0, 1'b0, 1'b0, "R1 zero word");
  endtask

  task automatic t_streaming();
    logic [31:0] g;
    logic [VLEN-1:0] e;
    g = enc(1, 1'b0, 2'd2, 5'd17);
    expect_bad(g, 1'b1, 1'b0, "R8 streaming blocked");
    e = model(g, pat(32'h2222_3333), pat(32'h4444_5555));
    issue(g, pat(32'h2222_3333), pat(32'h4444_5555), 1'b1, 1'b1);
    chk(res_valid_o && !illegal_o && result_o == e, "R8 streaming allowed", result_o, e);
  endtask

  task automatic t_idle();
    @(negedge clk);
    insn_i = enc(0, 1'b0, 2'd0, 5'd1); valid_i = 1'b0;
    @(negedge clk);
    chk(!res_valid_o && !illegal_o, "R10 no strobe without valid",
        VLEN'({res_valid_o, illegal_o}), '0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_packed();
    t_unpacked();
    t_wrap();
    t_bad_words();
    t_streaming();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule